// File: doc/BRIEF.md
# Tile Stripe Renderer with Movable Stripe Boundaries

This block paints the active area of a raster display as a row of side-by-side vertical bands. Each band takes its colour from its own 16×16 tile, and the tile repeats downward every sixteen lines. The upstream timing generator supplies the blanking, sync and pixel counters. The block returns the same timing delayed by one register stage, together with 8-bit red, green and blue values that line up with it.

The band for the current pixel comes from a chain of comparisons against the horizontal counter, and no sequencer is involved. In fixed mode the boundaries sit at whole multiples of the band width. In movable mode each band has its own start register, written by software through an address/data/strobe port. Written values wait in a pending bank. They move into the live bank only at the leading edge of vertical sync, so a boundary never shifts partway through a frame.

Top module: `tile_stripe_renderer`

## Requirements
- R1: `out_de`, `out_hs` and `out_vs` repeat `in_de`, `in_hs` and `in_vs` one clock later. While `rst_n` is low, every output is 0.
- R2: A clock in which `in_de` is low produces black (R = G = B = 0) on the next clock.
- R3: With `mode_prog` = 0 the band width is W = H_ACTIVE / N_STRIPES (80 by default). The band index k is the largest i in 1..N_STRIPES−1 with `hcount` ≥ i·W, or 0 when there is none. The tile column is bits [3:0] of `hcount` − k·W.
- R4: The tile row is `vcount[3:0]`, so the tile pattern repeats every 16 lines.
- R5: The texel at band k, column x and row y is coloured as follows: R = {y, x}, G = {x, y}, B = (32·k + (x XOR y)) mod 256. Here x and y are 4 bits wide and the first item in braces is the upper nibble.
- R6: With `mode_prog` = 1, live start value S[i] replaces i·W as the threshold for i ≥ 1. The largest such i whose threshold is crossed wins, even when the S values are not in ascending order. The tile column is bits [3:0] of `hcount` − S[k], and S[0] serves as the offset of band 0.
- R7: A clock with `wr_en` high stores `wr_data` into pending register `wr_addr`. The live bank copies the pending bank on each clock where `in_vs` is 1 after being 0 on the clock before. A write made on that same clock goes live only at the next such edge.
- R8: Reset loads both banks with S[i] = i·W, so movable mode matches fixed mode until the first write.
- R9: In fixed mode, register writes have no visible effect on the colour outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_prog | input | 1 | 0: fixed equal bands; 1: bands from live start registers |
| in_de | input | 1 | Active-video flag from the timing generator |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in |
| hcount | input | HCW (11) | Horizontal pixel counter |
| vcount | input | VCW (11) | Vertical line counter |
| wr_en | input | 1 | Start register write strobe |
| wr_addr | input | IDXW (3) | Band number being written |
| wr_data | input | HCW (11) | New start column |
| out_de | output | 1 | Delayed active-video flag |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
The bench writes start values that are out of order, beyond the visible width, and below the band-0 position. A selector that lets the first crossed threshold win, or that assumes ascending order, then paints the wrong band across whole spans of a line. A write mid-frame and a write on the exact clock of the sync edge check the frame boundary. A design that loads the live bank early would move the bands mid-picture, and one that forwards the edge-cycle write would show it a frame too soon. Lines past the sixteenth expose a missing vertical wrap. Writes made in fixed mode catch a design that lets the live bank leak into the fixed thresholds.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int TILE_LOG2 = 4;

  // Evenly spaced boundary for band i of width w
  function automatic int unsigned tsr_even_start(int unsigned i, int unsigned w);
    return i * w;
  endfunction

  // Texel colour for band k, column x, row y: {R, G, B}
  function automatic logic [23:0] tsr_texel(logic [7:0] k, logic [3:0] x, logic [3:0] y);
    logic [7:0] red;
    logic [7:0] grn;
    logic [7:0] blu;
    red = {y, x};
    grn = {x, y};
    blu = {k[2:0], 5'b0} + {4'b0, x ^ y};
    return {red, grn, blu};
  endfunction

endpackage

// File: rtl/tsr_start_bank.sv
module tsr_start_bank #(
  parameter int N_STRIPES = 8,
  parameter int HCW       = 11,
  parameter int STRIPE_W  = 80,
  parameter int IDXW      = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_addr,
  input  logic [HCW-1:0]           wr_data,
  input  logic                     frame_load,
  output logic [N_STRIPES*HCW-1:0] live_flat
);

  logic [HCW-1:0] pend_q [N_STRIPES];
  logic [HCW-1:0] live_q [N_STRIPES];

  for (genvar i = 0; i < N_STRIPES; i++) begin : g_slot
    localparam logic [HCW-1:0] RST_VAL = HCW'(tsr_pkg::tsr_even_start(i, STRIPE_W));
    logic hit;
    assign hit = wr_en && (int'(wr_addr) == i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[i] <= RST_VAL;
        live_q[i] <= RST_VAL;
      end else begin
        if (hit) pend_q[i] <= wr_data;
        if (frame_load) live_q[i] <= pend_q[i];
      end
    end

    assign live_flat[i*HCW +: HCW] = live_q[i];
  end

endmodule

// File: rtl/tsr_stripe_select.sv
module tsr_stripe_select #(
  parameter int N_STRIPES = 8,
  parameter int HCW       = 11,
  parameter int IDXW      = 3
) (
  input  logic [HCW-1:0]           hcount,
  input  logic [N_STRIPES*HCW-1:0] bounds_flat,
  output logic [IDXW-1:0]          sel_idx,
  output logic [HCW-1:0]           sel_base
);

  logic [IDXW-1:0] idx_c  [N_STRIPES];
  logic [HCW-1:0]  base_c [N_STRIPES];

  assign idx_c[0]  = '0;
  assign base_c[0] = bounds_flat[0 +: HCW];

  // Each later stage overrides the earlier ones when its threshold is crossed
  for (genvar i = 1; i < N_STRIPES; i++) begin : g_chain
    logic [HCW-1:0] thr;
    logic           crossed;
    assign thr      = bounds_flat[i*HCW +: HCW];
    assign crossed  = (hcount >= thr);
    assign idx_c[i]  = crossed ? IDXW'(i) : idx_c[i-1];
    assign base_c[i] = crossed ? thr      : base_c[i-1];
  end

  assign sel_idx  = idx_c[N_STRIPES-1];
  assign sel_base = base_c[N_STRIPES-1];

endmodule

// File: rtl/tsr_tile_rom.sv
module tsr_tile_rom #(
  parameter int IDXW = 3
) (
  input  logic [IDXW-1:0] tile_idx,
  input  logic [3:0]      col,
  input  logic [3:0]      row,
  output logic [23:0]     rgb
);

  assign rgb = tsr_pkg::tsr_texel(8'(tile_idx), col, row);

endmodule

// File: rtl/tile_stripe_renderer.sv
module tile_stripe_renderer #(
  parameter int N_STRIPES = 8,
  parameter int H_ACTIVE  = 640,
  parameter int HCW       = 11,
  parameter int VCW       = 11,
  localparam int IDXW     = (N_STRIPES > 1) ? $clog2(N_STRIPES) : 1,
  localparam int STRIPE_W = H_ACTIVE / N_STRIPES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_prog,
  input  logic            in_de,
  input  logic            in_hs,
  input  logic            in_vs,
  input  logic [HCW-1:0]  hcount,
  input  logic [VCW-1:0]  vcount,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_addr,
  input  logic [HCW-1:0]  wr_data,
  output logic            out_de,
  output logic            out_hs,
  output logic            out_vs,
  output logic [7:0]      out_r,
  output logic [7:0]      out_g,
  output logic [7:0]      out_b
);

  localparam int TL = tsr_pkg::TILE_LOG2;

  // Named internal events
  logic                     vs_q;
  logic                     frame_load;
  logic [N_STRIPES*HCW-1:0] live_flat;
  logic [N_STRIPES*HCW-1:0] fixed_flat;
  logic [N_STRIPES*HCW-1:0] bounds_flat;
  logic [IDXW-1:0]          sel_idx;
  logic [HCW-1:0]           sel_base;
  logic [HCW-1:0]           col_off;
  logic [23:0]              texel;
  logic                     unused_vhi;

  assign unused_vhi = ^vcount[VCW-1:TL];

  always_ff @(posedge clk) begin
    if (!rst_n) vs_q <= 1'b0;
    else        vs_q <= in_vs;
  end

  assign frame_load = in_vs && !vs_q;

  for (genvar i = 0; i < N_STRIPES; i++) begin : g_fixed
    assign fixed_flat[i*HCW +: HCW] = HCW'(tsr_pkg::tsr_even_start(i, STRIPE_W));
  end

  assign bounds_flat = mode_prog ? live_flat : fixed_flat;

  tsr_start_bank #(
    .N_STRIPES(N_STRIPES), .HCW(HCW), .STRIPE_W(STRIPE_W), .IDXW(IDXW)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_load(frame_load), .live_flat(live_flat)
  );

  tsr_stripe_select #(
    .N_STRIPES(N_STRIPES), .HCW(HCW), .IDXW(IDXW)
  ) u_sel (
    .hcount(hcount), .bounds_flat(bounds_flat),
    .sel_idx(sel_idx), .sel_base(sel_base)
  );

  assign col_off = hcount - sel_base;

  tsr_tile_rom #(.IDXW(IDXW)) u_rom (
    .tile_idx(sel_idx), .col(col_off[TL-1:0]), .row(vcount[TL-1:0]), .rgb(texel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_de <= 1'b0;
      out_hs <= 1'b0;
      out_vs <= 1'b0;
      out_r  <= '0;
      out_g  <= '0;
      out_b  <= '0;
    end else begin
      out_de <= in_de;
      out_hs <= in_hs;
      out_vs <= in_vs;
      if (in_de) {out_r, out_g, out_b} <= texel;
      else       {out_r, out_g, out_b} <= '0;
    end
  end

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int N_STRIPES = 8,
  parameter int HCW       = 11,
  parameter int IDXW      = 3,
  parameter int STRIPE_W  = 80
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_prog,
  input logic                     in_de,
  input logic                     in_hs,
  input logic                     in_vs,
  input logic [HCW-1:0]           hcount,
  input logic                     out_de,
  input logic                     out_hs,
  input logic                     out_vs,
  input logic [7:0]               out_r,
  input logic [7:0]               out_g,
  input logic [7:0]               out_b,
  input logic                     frame_load,
  input logic [IDXW-1:0]          sel_idx,
  input logic [HCW-1:0]           sel_base,
  input logic [N_STRIPES*HCW-1:0] live_flat
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_TIMING_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_de == $past(in_de)) && (out_hs == $past(in_hs)) && (out_vs == $past(in_vs))); // R1

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_r == 8'd0) && (out_g == 8'd0) && (out_b == 8'd0)); // R2

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_idx) < N_STRIPES); // R3

  AST_FIXED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_prog |-> int'(sel_base) == int'(sel_idx) * STRIPE_W); // R3

  AST_PROG_CROSSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_prog && sel_idx != '0) |-> hcount >= sel_base); // R6

  AST_LOAD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> frame_load == (in_vs && !$past(in_vs))); // R7

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(frame_load)) |-> $stable(live_flat)); // R7

endmodule

bind tile_stripe_renderer tsr_checker #(
  .N_STRIPES(N_STRIPES), .HCW(HCW), .IDXW(IDXW), .STRIPE_W(STRIPE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_prog(mode_prog), .in_de(in_de),
  .in_hs(in_hs), .in_vs(in_vs), .hcount(hcount), .out_de(out_de),
  .out_hs(out_hs), .out_vs(out_vs), .out_r(out_r), .out_g(out_g),
  .out_b(out_b), .frame_load(frame_load), .sel_idx(sel_idx),
  .sel_base(sel_base), .live_flat(live_flat)
);

// File: tb/tile_stripe_renderer_bench.sv
module tile_stripe_renderer_bench;

  localparam int N  = 8;
  localparam int HA = 640;
  localparam int W  = HA / N;
  localparam int HT = 660;
  localparam int VT = 40;
  localparam int VA = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_prog = 1'b1;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [10:0] hcount = '0, vcount = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [10:0] wr_data = '0;
  logic out_de, out_hs, out_vs;
  logic [7:0] out_r, out_g, out_b;

  always #5 clk = ~clk;

  tile_stripe_renderer u_tile_stripe_renderer (
    .clk(clk), .rst_n(rst_n), .mode_prog(mode_prog), .in_de(in_de),
    .in_hs(in_hs), .in_vs(in_vs), .hcount(hcount), .vcount(vcount),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .out_de(out_de),
    .out_hs(out_hs), .out_vs(out_vs), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  int frames = 0;
  string tag = "R8";
  bit done = 0;

  // Timing source: advances on falling edges
  int h = 0, v = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      h = h + 1;
      if (h == HT) begin
        h = 0;
        v = v + 1;
        if (v == VT) begin v = 0; frames = frames + 1; end
      end
    end
    hcount = 11'(h);
    vcount = 11'(v);
    in_de  = (h < HA) && (v < VA);
    in_hs  = (h >= 650) && (h < 656);
    in_vs  = (v >= 36) && (v < 38);
  end

  // Behavioural model: pending and live banks as integer arrays
  int pend [N];
  int live [N];
  bit vs_old;
  logic [26:0] exp_q[$];
  string tag_q[$];

  function automatic logic [23:0] colour(int k, int x, int y);
    int r, g, b;
    r = y * 16 + x;
    g = x * 16 + y;
    b = (k * 32 + (x ^ y)) % 256;
    return {8'(r), 8'(g), 8'(b)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin pend[i] = i * W; live[i] = i * W; end
      vs_old = 0;
      exp_q.delete();
      tag_q.delete();
    end else begin
      int st [N];
      int k, x, y;
      logic [23:0] c;
      for (int i = 0; i < N; i++) st[i] = mode_prog ? live[i] : i * W;
      k = 0;
      for (int i = N - 1; i >= 1; i--) begin
        if (int'(hcount) >= st[i]) begin k = i; break; end
      end
      x = (int'(hcount) - st[k]) & 15;
      y = int'(vcount) % 16;
      c = in_de ? colour(k, x, y) : 24'd0;
      exp_q.push_back({in_de, in_hs, in_vs, c});
      tag_q.push_back(tag);
      if (in_vs && !vs_old) for (int i = 0; i < N; i++) live[i] = pend[i];
      if (wr_en) pend[wr_addr] = int'(wr_data);
      vs_old = in_vs;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) begin
      n_vec = n_vec + 1;
      if ({out_de, out_hs, out_vs, out_r, out_g, out_b} != 27'd0) begin
        n_bad = n_bad + 1;
        $display("FAIL R1 reset outputs: got %h expected 0",
                 {out_de, out_hs, out_vs, out_r, out_g, out_b});
      end
    end else if (exp_q.size() > 0) begin
      logic [26:0] e;
      logic [26:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {out_de, out_hs, out_vs, out_r, out_g, out_b};
      n_vec = n_vec + 1;
      if (a != e) begin
        n_bad = n_bad + 1;
        if (a[26:24] != e[26:24]) t = "R1";
        else if (!e[26]) t = "R2";
        $display("FAIL %s h=%0d v=%0d: got %h expected %h", t, h, v, a, e);
      end
    end
  end

  task automatic wait_at(int vv, int hh);
    do @(posedge clk); while (!(v == vv && h == hh));
  endtask

  task automatic put(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 11'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // Frame 0, movable mode on reset values: bands equal to fixed spacing (R8, R3 R4 R5)
    tag = "R8 R4 R5";
    wait_at(10, 100);
    // Mid-frame writes must stay invisible until the next sync edge (R7)
    tag = "R7";
    put(1, 200); put(2, 150); put(3, 700); put(5, 300); put(0, 5);
    wait_at(0, 0);
    // Frame 1: out-of-order and off-screen thresholds, band 0 offset (R6)
    tag = "R6";
    wait_at(35, 659);
    put(4, 17);   // lands on the sync-edge clock: live only from frame 3 (R7)
    tag = "R7";
    wait_at(0, 0);
    wait_at(0, 0);
    // Frame 3 shows the edge-cycle write; frame 4 in fixed mode with writes (R9, R3)
    wait_at(38, 0);
    @(negedge clk);
    mode_prog = 1'b0;
    tag = "R9 R3";
    wait_at(5, 10);
    put(6, 3); put(7, 1); put(1, 600);
    wait_at(0, 0);
    wait_at(2, 0);
    finish_run();
  end

  initial begin
    wait (cycles > 190000);
    n_bad = n_bad + 1;
    $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
    finish_run();
  end

endmodule